// File: doc/BRIEF.md
# Coding-Violation Error-Rate Monitor

This block gives a coarse judgement of line quality by counting coding-violation pulses from a line decoder over a long observation window and comparing the total against a limit that corresponds to a bit error rate of one in a million. The window is timed by a slow time-base clock supplied from outside: 6 kHz when the line runs at 34368 kbit/s, and 1.5 kHz at 8448 kbit/s. Both cases use the same number of time-base periods per window, which gives 10 s and 40 s respectively.

The time-base clock is treated as asynchronous. It is brought into the line clock domain by a two-stage synchroniser, and its rising edges are counted there. At every window boundary a single-bit quality level is refreshed. The level is high if the window held more violations than the limit for the selected rate, and low otherwise. While the terminal side runs in rail-bypass mode, the decoder is not in use. In that mode the monitor stands still and keeps its output low.

Top module: `cv_rate_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `line_bad` is low and no window has progressed.
- R2: A window ends on the `TICKS_PER_WINDOW`-th rising edge of `tb_clk` (default 60000, the same at both rates). A rising edge of `tb_clk` first sampled high at clock edge k is counted at clock edge k+2.
- R3: At a window end, `line_bad` becomes 1 if the violations counted in that window, including one in the boundary cycle itself, exceed the threshold. Otherwise it becomes 0. Between window ends `line_bad` holds its value.
- R4: The threshold is `TH_HI` (default 344) when `rate_hi` = 1 and `TH_LO` (default 338) when `rate_hi` = 0. It is taken from `rate_hi` in the boundary cycle.
- R5: The violation count is cleared at each window end. A violation in the cycle after a boundary belongs to the next window.
- R6: The violation count saturates instead of wrapping, so any number of violations above the threshold is still judged above it.
- R7: When `codec_en` = 0 (rail-bypass mode), `cv_pulse` is ignored and `line_bad` is 0 from the next clock edge. The window position returns to zero, so after `codec_en` returns to 1 the first window is a full `TICKS_PER_WINDOW` ticks long.
- R8: With exactly threshold violations in a window, `line_bad` is 0. With threshold plus one violations, it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cv_pulse | input | 1 | One-cycle coding-violation pulse from the decoder, line clock domain |
| tb_clk | input | 1 | Slow time-base clock, asynchronous to `clk` |
| rate_hi | input | 1 | 1 selects the high line rate threshold, 0 the low one |
| codec_en | input | 1 | 1 when the line code decoder is active; 0 in rail-bypass mode |
| line_bad | output | 1 | Line quality level, 1 when the last window exceeded the threshold |

## Verification
Violation patterns are driven per window: none, exactly the threshold, one over it, and a burst large enough to overrun a wrapping counter. Together these separate the strict comparison from an inclusive one and a saturating count from a wrapping one. A count lying between the two thresholds is presented at both rate settings, which shows that the threshold follows `rate_hi` at the boundary. Random-density windows place violations on and next to boundary cycles, which tells apart correct boundary attribution and clearing. Rail-bypass intervals driven in mid-window, with heavy violations, show that the output is forced low and that the window restarts from zero.

// File: rtl/cv_rate_monitor.sv
module cv_rate_monitor #(
  parameter int unsigned TICKS_PER_WINDOW = 60000,
  parameter int unsigned TH_HI = 344,
  parameter int unsigned TH_LO = 338
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cv_pulse,
  input  logic tb_clk,
  input  logic rate_hi,
  input  logic codec_en,
  output logic line_bad
);
  localparam int unsigned TH_MAX = (TH_HI > TH_LO) ? TH_HI : TH_LO;
  localparam int unsigned CW = $clog2(TH_MAX + 2);
  localparam int unsigned WW = $clog2(TICKS_PER_WINDOW + 1);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [WW-1:0] LAST_TICK = WW'(TICKS_PER_WINDOW - 1);

  logic [2:0]    tb_sync;
  logic [WW-1:0] wcnt;
  logic [CW-1:0] vcnt;
  logic [CW:0]   total;
  logic [CW-1:0] th;
  logic          tick, win_end, cv_in;

  assign tick    = tb_sync[1] & ~tb_sync[2];
  assign win_end = codec_en & tick & (wcnt == LAST_TICK);
  assign cv_in   = codec_en & cv_pulse;
  assign total   = {1'b0, vcnt} + {{CW{1'b0}}, cv_in};
  assign th      = rate_hi ? CW'(TH_HI) : CW'(TH_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) tb_sync <= '0;
    else        tb_sync <= {tb_sync[1:0], tb_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !codec_en) begin
      wcnt     <= '0;
      vcnt     <= '0;
      line_bad <= 1'b0;
    end else begin
      if (tick) wcnt <= win_end ? '0 : wcnt + 1'b1;
      if (win_end) begin
        line_bad <= total > {1'b0, th};
        vcnt     <= '0;
      end else if (total[CW]) begin
        vcnt <= CNT_MAX;
      end else begin
        vcnt <= total[CW-1:0];
      end
    end
  end
endmodule

module cv_rate_monitor_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 3,
  parameter int unsigned WW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          codec_en,
  input logic          line_bad,
  input logic          win_end,
  input logic [CW-1:0] vcnt,
  input logic [WW-1:0] wcnt
);
  a_r3_hold_between_windows: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && codec_en) |=> $stable(line_bad));
  a_r5_clear_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (vcnt == '0));
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_en && !win_end && vcnt == {CW{1'b1}}) |=> (vcnt == {CW{1'b1}}));
  a_r7_rail_low: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_en |=> (!line_bad && wcnt == '0 && vcnt == '0));
  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < WW'(N));
endmodule

bind cv_rate_monitor cv_rate_monitor_chk #(.N(TICKS_PER_WINDOW), .CW(CW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .codec_en(codec_en), .line_bad(line_bad),
  .win_end(win_end), .vcnt(vcnt), .wcnt(wcnt)
);

// File: tb/sim_cv_rate_monitor.sv
module sim_cv_rate_monitor;
  localparam int N = 8, THH = 5, THL = 3, HALF_TB = 4;
  localparam int WIN = 2 * HALF_TB * N;

  logic clk = 0, rst_n = 0, cv_pulse = 0, tb_clk = 0, rate_hi = 1, codec_en = 1;
  logic line_bad;
  int checks = 0, errors = 0;
  string phase = "R1";
  bit tb_run = 0;

  cv_rate_monitor #(.TICKS_PER_WINDOW(N), .TH_HI(THH), .TH_LO(THL)) u0 (
    .clk(clk), .rst_n(rst_n), .cv_pulse(cv_pulse), .tb_clk(tb_clk),
    .rate_hi(rate_hi), .codec_en(codec_en), .line_bad(line_bad));

  always #2.5 clk = ~clk;

  initial forever begin
    repeat (HALF_TB) @(negedge clk);
    if (tb_run) tb_clk = ~tb_clk;
  end

  // behavioural reference
  int h0 = 0, h1 = 0, h2 = 0, m_wc = 0, m_vc = 0, m_out = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; m_wc = 0; m_vc = 0; m_out = 0;
    end else begin
      bit tk;
      tk = (h1 == 1) && (h2 == 0);
      if (!codec_en) begin
        m_wc = 0; m_vc = 0; m_out = 0;
      end else begin
        if (tk && m_wc == N - 1) begin
          m_out = ((m_vc + int'(cv_pulse)) > (rate_hi ? THH : THL)) ? 1 : 0;
          m_vc = 0; m_wc = 0;
        end else begin
          if (tk) m_wc++;
          m_vc += int'(cv_pulse);
        end
      end
      h2 = h1; h1 = h0; h0 = int'(tb_clk);
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (int'(line_bad) != m_out) begin
      errors++;
      $display("FAIL %s t=%0t line_bad actual=%0d expected=%0d", phase, $time, line_bad, m_out);
    end
  end

  task automatic pulses(input int k, input int span);
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      cv_pulse = (i < k);
    end
    @(negedge clk); cv_pulse = 0;
  endtask

  task automatic rand_window(input int pct, input int nwin);
    for (int i = 0; i < WIN * nwin; i++) begin
      @(negedge clk);
      cv_pulse = ($urandom_range(99) < pct);
    end
    @(negedge clk); cv_pulse = 0;
  endtask

  task automatic expect_now(input string req, input int exp);
    @(negedge clk);
    checks++;
    if (int'(line_bad) != exp) begin
      errors++;
      $display("FAIL %s line_bad actual=%0d expected=%0d", req, line_bad, exp);
    end
  endtask

  initial begin
    bit timeout = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        expect_now("R1", 0);
        rst_n = 1;
        expect_now("R1", 0);
        tb_run = 1;
        phase = "R2"; pulses(0, WIN * 2);
        phase = "R8"; pulses(THH, WIN);
        pulses(THH + 1, WIN);
        pulses(0, WIN);
        phase = "R4"; rate_hi = 0; pulses(THL + 1, WIN);
        rate_hi = 1; pulses(THL + 1, WIN);
        phase = "R6"; pulses(11, WIN); pulses(15, WIN);
        phase = "R7"; pulses(THH + 1, WIN);
        pulses(0, WIN / 2);
        codec_en = 0; pulses(20, WIN);
        expect_now("R7", 0);
        codec_en = 1; pulses(THH + 2, WIN + WIN / 3);
        pulses(0, WIN * 2);
        phase = "R3"; rand_window(6, 4);
        phase = "R5"; rand_window(12, 6);
        rate_hi = 0; rand_window(5, 6);
        codec_en = 0; rand_window(50, 1); codec_en = 1;
        rand_window(9, 6);
        pulses(0, WIN * 2);
        expect_now("R5", 0);
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule